// File: doc/BRIEF.md
# Minimum Edge Spacing Data Conditioner

This block turns the raw bit coming out of an amplitude demodulator into a clean data level for a host. The raw bit is first brought into the system clock domain through a short synchronizer chain. It is then looked at only on clock cycles that carry the extended tick enable. An output edge is allowed only on such a tick. Each edge starts a hold-off window during which the output is frozen. Spikes and short gaps therefore cannot reach the host, and the rate of edges at its interrupt pin is bounded.

A sequencer owns the `armed` flag. While `armed` is low, the output is held at its idle-high level and the hold-off is cleared. As a result, the first edge after arming is always a falling one, and it can happen on the first tick. The extended tick is generated outside this block. Its period, 8, 4, 2 or 1 basic ticks depending on the baud range, changes how long the hold-off lasts in time but does not change its length in ticks.

Top module: `edge_gap_conditioner`

## Requirements
- R1: `dataOut` changes while `armed` is high only on a clock cycle where `tickEn` is 1; raw input changes between ticks have no effect on the output.
- R2: After an output edge, no further edge occurs on the next 9 ticks, so the shortest edge-to-edge interval is 10 ticks (HOLD_TICKS).
- R3: On a tick where the hold-off has expired and the synchronized input differs from `dataOut`, `dataOut` takes the input level on that tick and a new hold-off starts.
- R4: An input pulse or gap that begins and ends inside a hold-off window produces no output edges.
- R5: The raw bit passes through two flops before it is sampled. A change driven in the cycle of clock edge P0 is first acted on by a tick at clock edge P0+3.
- R6: While `armed` is low, `dataOut` is 1 from the next clock edge, ticks and input have no effect, and the hold-off is cleared, so the first tick after arming may produce an edge.
- R7: During and directly after reset, `dataOut` is 1.
- R8: The first output edge after `armed` rises is a falling edge (1 to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle extended tick enable |
| armed | input | 1 | Receive permission from the sequencer; low forces idle |
| rawBit | input | 1 | Raw demodulated bit, asynchronous |
| dataOut | output | 1 | Conditioned data level, idle high |

## Verification
The properties assume that `tickEn` and `armed` are synchronous to `clk`, and that `rawBit` is the only asynchronous input. They also compare each output change against the tick and hold-off state of the previous cycle, so they assume the reset is long enough to load every register. The stimulus drives all inputs on the falling clock edge. It changes `rawBit` at least three clocks before the tick that is meant to see it, except in the latency test, which places the tick deliberately at one and two clocks. Ticks are one cycle wide, except in that same latency test.

// File: rtl/edge_gap_pkg.sv
package edge_gap_pkg;

  // Strobes from control to datapath; at most one action group per cycle
  typedef struct packed {
    logic clearAll;   // force idle level, empty the hold-off
    logic reload;     // start a fresh hold-off window
    logic countDown;  // one tick of hold-off consumed
    logic flip;       // toggle the output level
  } holdStrobe_t;

endpackage

// File: rtl/edge_gap_path.sv
module edge_gap_path
  import edge_gap_pkg::*;
#(
  parameter int HOLD_TICKS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rawBit,
  input  holdStrobe_t stb,
  output logic        syncBit,
  output logic        holdZero,
  output logic        dataOut
);

  localparam int CNT_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] holdCnt;

  // Synchronizer chain, idle level high
  generate
    if (SYNC_STAGES >= 2) begin : gSyncChain
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], rawBit};
      end
      assign syncBit = syncChain[SYNC_STAGES-1];
    end else begin : gSyncSingle
      logic syncFf;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncFf <= 1'b1;
        else       syncFf <= rawBit;
      end
      assign syncBit = syncFf;
    end
  endgenerate

  // Hold-off counter: ticks left before the next edge is allowed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdCnt <= '0;
    else if (stb.clearAll)  holdCnt <= '0;
    else if (stb.reload)    holdCnt <= RELOAD;
    else if (stb.countDown) holdCnt <= holdCnt - 1'b1;
  end

  assign holdZero = (holdCnt == '0);

  // Output level register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataOut <= 1'b1;
    else if (stb.clearAll) dataOut <= 1'b1;
    else if (stb.flip)     dataOut <= ~dataOut;
  end

  // R2: a running hold-off freezes the output
  assert_hold_freezes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (($past(holdCnt) != '0) && !$past(stb.clearAll)) |-> $stable(dataOut));

  // R2: every edge leaves a full window behind it
  assert_edge_reloads_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((dataOut != $past(dataOut)) && !$past(stb.clearAll)) |-> (holdCnt == RELOAD));

endmodule

// File: rtl/edge_gap_ctrl.sv
module edge_gap_ctrl
  import edge_gap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armed,
  input  logic        tickEn,
  input  logic        syncBit,
  input  logic        holdZero,
  input  logic        dataOut,
  output holdStrobe_t stb
);

  always_comb begin
    stb = '0;
    if (!armed) begin
      stb.clearAll = 1'b1;
    end else if (tickEn) begin
      if (!holdZero) begin
        stb.countDown = 1'b1;
      end else if (syncBit != dataOut) begin
        stb.flip   = 1'b1;
        stb.reload = 1'b1;
      end
    end
  end

  // R1: armed output edges only on ticks with an empty hold-off
  assert_edge_on_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(armed) && (dataOut != $past(dataOut))) |-> ($past(tickEn) && $past(holdZero)));

  // R3: an eligible tick with differing input copies the input
  assert_follow_input_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(armed) && $past(tickEn) && $past(holdZero) && ($past(syncBit) != $past(dataOut)))
      |-> (dataOut == $past(syncBit)));

  // R6: disarmed means idle high
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(armed) |-> dataOut);

endmodule

// File: rtl/edge_gap_conditioner.sv
module edge_gap_conditioner
  import edge_gap_pkg::*;
#(
  parameter int HOLD_TICKS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic armed,
  input  logic rawBit,
  output logic dataOut
);

  holdStrobe_t stb;
  logic        syncBit;
  logic        holdZero;

  edge_gap_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .armed    (armed),
    .tickEn   (tickEn),
    .syncBit  (syncBit),
    .holdZero (holdZero),
    .dataOut  (dataOut),
    .stb      (stb)
  );

  edge_gap_path #(
    .HOLD_TICKS  (HOLD_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .rawBit   (rawBit),
    .stb      (stb),
    .syncBit  (syncBit),
    .holdZero (holdZero),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/test_edge_gap_conditioner.sv
module test_edge_gap_conditioner;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  // Each entry: {raw level driven before the tick, expected dataOut after it}
  localparam logic [1:0] VEC [NVEC] = '{
    2'b11, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b00, 2'b10, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11,
    2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic armed = 1'b0;
  logic rawBit = 1'b1;
  logic dataOut;
  int   checks = 0;
  int   errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  edge_gap_conditioner i_edge_gap_conditioner (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .armed   (armed),
    .rawBit  (rawBit),
    .dataOut (dataOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dataOut=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive raw, let it settle through the synchronizer, give one tick, sample
  task automatic doTick(input logic raw);
    @(negedge clk);
    rawBit = raw;
    tickEn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: dataOut=%0b expected run end", dataOut);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7 reset state
    repeat (3) @(negedge clk);
    check("R7 in reset", dataOut, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after reset", dataOut, 1'b1);
    armed = 1'b1;

    // Table walk: R2 spacing, R3 follow, R4 short pulse/gap, R8 falling first
    for (int i = 0; i < NVEC; i++) begin
      doTick(VEC[i][1]);
      check($sformatf("R2/R3/R4/R8 vec %0d", i), dataOut, VEC[i][0]);
    end

    // R6: disarm mid hold-off, output high next clock, input ignored
    @(negedge clk);
    armed = 1'b0;
    @(negedge clk);
    check("R6 forced high", dataOut, 1'b1);
    for (int i = 0; i < 3; i++) begin
      doTick(1'b0);
      check("R6 ignored while disarmed", dataOut, 1'b1);
    end

    // R6/R8: re-arm, hold-off cleared, first tick gives a falling edge
    @(negedge clk);
    armed = 1'b1;
    doTick(1'b0);
    check("R8 first edge falls", dataOut, 1'b0);
    for (int i = 0; i < 9; i++) doTick(1'b1);
    check("R2 held through 9 ticks", dataOut, 1'b0);
    doTick(1'b1);
    check("R3 edge on tenth tick", dataOut, 1'b1);

    // R1: hold-off expires, input changes, no tick means no change
    for (int i = 0; i < 9; i++) doTick(1'b1);
    @(negedge clk);
    rawBit = 1'b0;
    repeat (8) @(negedge clk);
    check("R1 no tick no change", dataOut, 1'b1);
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    check("R1 tick takes input", dataOut, 1'b0);

    // R5: synchronizer latency
    for (int i = 0; i < 9; i++) doTick(1'b0);
    @(negedge clk);
    rawBit = 1'b1;
    tickEn = 1'b1;
    @(negedge clk);
    check("R5 not seen after one clock", dataOut, 1'b0);
    @(negedge clk);
    check("R5 not seen after two clocks", dataOut, 1'b0);
    @(negedge clk);
    tickEn = 1'b0;
    check("R5 seen on third clock", dataOut, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule